// File: doc/BRIEF.md
# IF Synthesizer Divider Chain

This block is the digital divider path of an IF frequency synthesizer. A reference divider runs on the reference clock and emits a one-cycle strobe every R reference cycles, with R picked from a fixed set of four ratios by a two-bit code. A fixed divide-by-two prescaler runs on the local-oscillator clock and feeds a programmable main divider. That divider emits a one-cycle strobe every N prescaler periods, so the strobe recurs every 2N local-oscillator cycles. A phase detector outside this block compares the two strobes.

The ratio codes and a two-bit test code come from a register bank. Each divider takes a new ratio only at its own terminal count, so every divider period has the full length of one ratio. This reload point is also where the register values cross into the divider's clock domain. The test code selects which internal signal drives the lock/test pin. It also gates the enables of the I and Q transmit mixers, so code 11 silences the transmitter even while it is powered.

Top module: `synth_div_chain`

## Requirements
- R1: The reference strobe period in reference clocks is 8, 11, 22 or 44 for ref_code 00, 01, 10 or 11 respectively.
- R2: The reference divider starts from ratio 22 after reset. The first reference strobe appears 22 reference clocks after reset is released, whatever the value of ref_code.
- R3: main_strobe recurs every 2·N lo_clk cycles, where N is main_ratio and N lies in the range 64 to 511.
- R4: The main divider starts from ratio 352 after reset. The first main_strobe appears 704 lo_clk cycles after reset is released, whatever the value of main_ratio.
- R5: A ratio change made in the middle of a divider period does not alter the length of that period. The new ratio applies from the next terminal count onward.
- R6: A main_ratio below 64 is treated as 64, which gives a period of 128 lo_clk cycles.
- R7: main_ratio 511 gives a period of 1022 lo_clk cycles.
- R8: ref_strobe is high for exactly one reference clock per period. main_strobe is high for exactly one lo_clk cycle per period.
- R9: test_out follows test_code as follows. 00 selects lock_in. 01 selects ref_strobe. 10 selects a level that toggles at every main terminal count (the LO/2 chain divided by N). 11 selects main_strobe.
- R10: mixer_q_en is low exactly when test_code[0] is 1. mixer_i_en is low exactly when test_code[1] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| lo_clk | input | 1 | Local-oscillator input clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| ref_code | input | 2 | Reference ratio code |
| main_ratio | input | 9 | Main divider ratio N |
| test_code | input | 2 | Test selection code (bit 0 and bit 1) |
| lock_in | input | 1 | Normal lock indication from the phase detector |
| ref_strobe | output | 1 | Reference divider strobe (ref_clk domain) |
| main_strobe | output | 1 | Main divider strobe (lo_clk domain) |
| test_out | output | 1 | Lock/test pin |
| mixer_i_en | output | 1 | I transmit mixer enable |
| mixer_q_en | output | 1 | Q transmit mixer enable |

## Verification
The bench measures every strobe interval and checks the first period after reset against the reset ratios while the inputs ask for something else. A design that reloaded from the inputs straight out of reset would show 8 or 200 cycles there instead of 22 or 704. Each ratio change is made in the middle of a period, and the bench expects that period to keep the old length. A design that reloaded at once would produce a truncated or stretched interval. The bench also measures a ratio below the floor, where a missing clamp would give a short period or a wrapped one, and the 511 limit, where an off-by-one shows as 1020 or 1024. For the mux, the bench checks all four codes. It checks that the toggle level changes exactly on main strobes, and that each mixer enable tracks its own bit, so swapped bits are caught.

// File: rtl/synth_div_chain.sv
`timescale 1ns/1ps
module synth_div_chain #(
  parameter int         N_W            = 9,
  parameter int         N_MIN          = 64,
  parameter int         N_RESET        = 352,
  parameter logic [1:0] REF_CODE_RESET = 2'b10
) (
  input  logic           ref_clk,
  input  logic           lo_clk,
  input  logic           rst_n,
  input  logic [1:0]     ref_code,
  input  logic [N_W-1:0] main_ratio,
  input  logic [1:0]     test_code,
  input  logic           lock_in,
  output logic           ref_strobe,
  output logic           main_strobe,
  output logic           test_out,
  output logic           mixer_i_en,
  output logic           mixer_q_en
);
  localparam int             REF_W     = 6;
  localparam logic [N_W-1:0] N_MIN_V   = N_W'(N_MIN);
  localparam logic [N_W-1:0] N_RST_LST = N_W'(N_RESET - 1);

  function automatic logic [REF_W-1:0] ref_last(input logic [1:0] c);
    case (c)
      2'b00:   return REF_W'(7);
      2'b01:   return REF_W'(10);
      2'b10:   return REF_W'(21);
      default: return REF_W'(43);
    endcase
  endfunction

  // reference domain
  logic [REF_W-1:0] ref_cnt;
  logic             ref_stb_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt   <= ref_last(REF_CODE_RESET);
      ref_stb_q <= 1'b0;
    end else begin
      ref_stb_q <= (ref_cnt == '0);
      ref_cnt   <= (ref_cnt == '0) ? ref_last(ref_code) : ref_cnt - 1'b1;
    end
  end

  p_ref_single_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_stb_q |=> !ref_stb_q);
  p_ref_bound_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_cnt <= REF_W'(43));

  // local-oscillator domain: divide-by-two enable, then divide by N
  logic           pre_q;
  logic [N_W-1:0] main_cnt;
  logic           main_stb_q;
  logic           main_tog;
  logic [N_W-1:0] n_eff;

  assign n_eff = (main_ratio < N_MIN_V) ? N_MIN_V : main_ratio;

  always_ff @(posedge lo_clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= 1'b0;
      main_cnt   <= N_RST_LST;
      main_stb_q <= 1'b0;
      main_tog   <= 1'b0;
    end else begin
      pre_q      <= ~pre_q;
      main_stb_q <= pre_q && (main_cnt == '0);
      if (pre_q) begin
        if (main_cnt == '0) begin
          main_cnt <= n_eff - 1'b1;
          main_tog <= ~main_tog;
        end else begin
          main_cnt <= main_cnt - 1'b1;
        end
      end
    end
  end

  p_main_single_r8: assert property (@(posedge lo_clk) disable iff (!rst_n)
    main_stb_q |=> !main_stb_q);
  p_main_on_enable_r3: assert property (@(posedge lo_clk) disable iff (!rst_n)
    main_stb_q |-> !pre_q);
  p_main_floor_r6: assert property (@(posedge lo_clk) disable iff (!rst_n)
    main_stb_q |-> (main_cnt >= N_MIN_V - 1'b1));

  // outputs
  assign ref_strobe  = ref_stb_q;
  assign main_strobe = main_stb_q;

  always_comb begin
    case (test_code)
      2'b00:   test_out = lock_in;
      2'b01:   test_out = ref_stb_q;
      2'b10:   test_out = main_tog;
      default: test_out = main_stb_q;
    endcase
  end

  assign mixer_q_en = ~test_code[0];
  assign mixer_i_en = ~test_code[1];
endmodule

// File: tb/synth_div_chain_tb_top.sv
`timescale 1ns/1ps
module synth_div_chain_tb_top;
  logic       ref_clk = 1'b0;
  logic       lo_clk  = 1'b0;
  logic       rst_n;
  logic [1:0] ref_code;
  logic [8:0] main_ratio;
  logic [1:0] test_code;
  logic       lock_in;
  logic       ref_strobe, main_strobe, test_out, mixer_i_en, mixer_q_en;

  int checks = 0;
  int failures = 0;

  int    rq[$];
  string rtag[$];
  int    mq[$];
  string mtag[$];

  always #5 ref_clk = ~ref_clk;
  always #3 lo_clk  = ~lo_clk;

  synth_div_chain dut_i (
    .ref_clk(ref_clk), .lo_clk(lo_clk), .rst_n(rst_n),
    .ref_code(ref_code), .main_ratio(main_ratio), .test_code(test_code),
    .lock_in(lock_in), .ref_strobe(ref_strobe), .main_strobe(main_strobe),
    .test_out(test_out), .mixer_i_en(mixer_i_en), .mixer_q_en(mixer_q_en)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // monitors: pop one expected interval per strobe
  initial begin
    int edges = 0;
    forever begin
      @(negedge ref_clk);
      if (!rst_n) edges = 0;
      else begin
        edges++;
        if (ref_strobe) begin
          if (rq.size() != 0) begin
            int e;
            string t;
            e = rq.pop_front();
            t = rtag.pop_front();
            check(edges == e, t, edges, e);
          end
          edges = 0;
        end
      end
    end
  end

  initial begin
    int edges = 0;
    forever begin
      @(negedge lo_clk);
      if (!rst_n) edges = 0;
      else begin
        edges++;
        if (main_strobe) begin
          if (mq.size() != 0) begin
            int e;
            string t;
            e = mq.pop_front();
            t = mtag.pop_front();
            check(edges == e, t, edges, e);
          end
          edges = 0;
        end
      end
    end
  end

  task automatic ref_change(input logic [1:0] code, input int old_len, input int new_len);
    @(negedge ref_clk iff ref_strobe);
    @(posedge ref_clk);
    #1;
    ref_code = code;
    rq.push_back(old_len); rtag.push_back("R5 ref mid-period change");
    rq.push_back(new_len); rtag.push_back("R1 ref ratio");
    rq.push_back(new_len); rtag.push_back("R1 ref ratio");
    while (rq.size() != 0) @(negedge ref_clk);
  endtask

  task automatic main_change(input int n, input int old_len, input int new_len, input string tag);
    @(negedge lo_clk iff main_strobe);
    @(posedge lo_clk);
    #1;
    main_ratio = 9'(n);
    mq.push_back(old_len); mtag.push_back("R5 main mid-period change");
    mq.push_back(new_len); mtag.push_back(tag);
    mq.push_back(new_len); mtag.push_back(tag);
    while (mq.size() != 0) @(negedge lo_clk);
  endtask

  task automatic check_mixers;
    for (int c = 0; c < 4; c++) begin
      test_code = 2'(c);
      #1;
      check(mixer_q_en == !test_code[0], "R10 q mixer enable", int'(mixer_q_en), int'(!test_code[0]));
      check(mixer_i_en == !test_code[1], "R10 i mixer enable", int'(mixer_i_en), int'(!test_code[1]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mism;
    int seen;
    int dbl;
    logic prev;
    rst_n = 1'b0;
    ref_code = 2'b00;
    main_ratio = 9'd100;
    test_code = 2'b00;
    lock_in = 1'b0;
    #20;
    check(ref_strobe == 1'b0, "R8 ref strobe low in reset", int'(ref_strobe), 0);
    check(main_strobe == 1'b0, "R8 main strobe low in reset", int'(main_strobe), 0);
    check(mixer_i_en && mixer_q_en, "R10 mixers enabled in reset", int'({mixer_i_en, mixer_q_en}), 3);
    rq.push_back(22); rtag.push_back("R2 reset ref ratio");
    rq.push_back(8);  rtag.push_back("R1 ref ratio 00");
    rq.push_back(8);  rtag.push_back("R1 ref ratio 00");
    mq.push_back(704); mtag.push_back("R4 reset main ratio");
    mq.push_back(200); mtag.push_back("R3 main ratio 100");
    mq.push_back(200); mtag.push_back("R3 main ratio 100");
    @(negedge ref_clk);
    rst_n = 1'b1;
    while (rq.size() != 0) @(negedge ref_clk);
    ref_change(2'b01, 8, 11);
    ref_change(2'b10, 11, 22);
    ref_change(2'b11, 22, 44);
    ref_change(2'b00, 44, 8);
    while (mq.size() != 0) @(negedge lo_clk);
    main_change(64, 200, 128, "R3 main ratio 64");
    main_change(10, 128, 128, "R6 clamp to 64");
    main_change(511, 128, 1022, "R7 main ratio 511");
    main_change(352, 1022, 704, "R3 main ratio 352");

    // R9 lock path
    test_code = 2'b00;
    lock_in = 1'b1;
    #1;
    check(test_out == 1'b1, "R9 code 00 lock high", int'(test_out), 1);
    lock_in = 1'b0;
    #1;
    check(test_out == 1'b0, "R9 code 00 lock low", int'(test_out), 0);

    // R9 reference strobe routed, R8 width
    test_code = 2'b01;
    mism = 0; seen = 0; dbl = 0; prev = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge ref_clk);
      if (test_out != ref_strobe) mism++;
      if (ref_strobe) seen++;
      if (ref_strobe && prev) dbl++;
      prev = ref_strobe;
    end
    check(mism == 0 && seen == 25, "R9 code 01 ref strobe", mism * 1000 + seen, 25);
    check(dbl == 0, "R8 ref strobe single cycle", dbl, 0);

    // R9 main strobe routed, R8 width
    test_code = 2'b11;
    mism = 0; seen = 0; dbl = 0; prev = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge lo_clk);
      if (test_out != main_strobe) mism++;
      if (main_strobe) seen++;
      if (main_strobe && prev) dbl++;
      prev = main_strobe;
    end
    check(mism == 0 && seen >= 4, "R9 code 11 main strobe", mism * 1000 + seen, 4);
    check(dbl == 0, "R8 main strobe single cycle", dbl, 0);

    // R9 toggle level changes only on main terminal count
    test_code = 2'b10;
    @(negedge lo_clk);
    prev = test_out;
    mism = 0; seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge lo_clk);
      if ((test_out != prev) != main_strobe) mism++;
      if (main_strobe) seen++;
      prev = test_out;
    end
    check(mism == 0 && seen >= 4, "R9 code 10 toggle", mism * 1000 + seen, 4);

    check_mixers();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule